// File: doc/BRIEF.md
# Backlight PWM Generator with Lockable Double-Buffered Update

This block drives a panel backlight from a pulse-width-modulated pin. Software programs a duty word, a period word and a bit-count that sets how wide the period and the integer part of the duty are. A free-running period counter compares against the integer duty, so the pin is high for that many cycles of each period. An optional dithering mode takes the low, fractional bits of the duty word and adds one extra high cycle in those periods where a fraction accumulator overflows. Over many periods this gives a finer average brightness.

Duty and period writes never reach the comparator directly. They land in shadow registers and are copied to the active set only at a period boundary, so a period never mixes old and new settings. A group lock, honoured when its companion override bit is also set, holds the shadow values back for as long as needed. This lets software stage several writes and release them together. A pending flag tells software that staged values have not yet been applied. The output enable acts at once and is not buffered.

Top module: `bl_pwm_locked`

## Requirements
- R1: After reset the pin is low and the pending flag is low.
- R2: While the enable bit (register 2, bit 0) is 0 the pin is held low, and the bit acts on the cycle after it is written.
- R3: The period register (register 1) holds the period in bits [15:0] and a bit-count in bits [20:16]. The effective period is the period masked to its bit-count low bits, and a bit-count of 0 means 16. The counter runs from 0 to period-1.
- R4: When the masked period is 0, the period is taken as all ones of the bit-count width. With bit-count 4 that gives 15 cycles.
- R5: The integer duty is the top bit-count bits of the 16-bit duty (register 0, bits [15:0]). The pin is high while the counter is below the integer duty. A duty of 0 gives a constant low, and a duty at or above the period gives a constant high.
- R6: With the dither bit (register 0, bit 16) clear, the low 16 minus bit-count duty bits have no effect on the output.
- R7: With the dither bit set, the low duty bits are added to an accumulator once per period, and each carry adds one high cycle to the following period. A half-scale fraction yields two extra high cycles in every four periods.
- R8: A write to register 0 or 1 takes effect only from the first cycle of the next period. The rest of the current period uses the old values.
- R9: While the group lock (register 3, bit 0) and the override bit (register 3, bit 1) are both set, staged values are not applied and the pending flag stays high. Clearing the lock applies them at the next period boundary.
- R10: A group lock written without the override bit has no effect, and staged values are applied at the next boundary.
- R11: A write to register 0 or 1 raises the pending flag on the next cycle. The flag falls in the same cycle that the new values become active, which is the first cycle of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 duty, 1 period, 2 enable, 3 lock |
| wr_data | input | DATA_W | Write data |
| pwm_o | output | 1 | Backlight PWM pin |
| pending_o | output | 1 | Staged values not yet applied |

## Verification
The bound checker covers the properties that hold on every cycle:
- the pin stays low while disabled;
- the counter stays inside the active period;
- the active duty changes only at a boundary and never while locked;
- the pending flag rises after every staged write, holds while locked and falls only on a transfer.

The directed scenarios cover what only a whole period or a sequence of periods can show: high-cycle counts and period lengths for the masked, zero and full-width bit-count cases, and the dither average over four periods. They also show that a mid-period write leaves the rest of that period unchanged, and that the lock holds staged values over several periods but is ignored without its override bit.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
   // register select codes on the write port
   typedef enum logic [1:0] {
      ADR_DUTY   = 2'd0,
      ADR_PERIOD = 2'd1,
      ADR_ENABLE = 2'd2,
      ADR_LOCK   = 2'd3
   } reg_addr_e;

   // width of the bit-count field for a given counter width
   function automatic int unsigned bitcnt_width(input int unsigned w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
   import bl_pwm_pkg::*;
#(
   parameter int unsigned DUTY_W = 16,
   parameter int unsigned BC_W   = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wrap,
   output logic [DUTY_W-1:0] act_duty,
   output logic              act_frac,
   output logic [DUTY_W-1:0] act_period,
   output logic [BC_W-1:0]   act_bc,
   output logic              out_en,
   output logic              eff_lock,
   output logic              xfer,
   output logic              pending
);
   logic [DUTY_W-1:0] sh_duty, sh_period;
   logic              sh_frac;
   logic [BC_W-1:0]   sh_bc;
   logic              grp_lock, lock_override;
   logic              stage_wr;

   wire unused_hi = ^wr_data[DATA_W-1:DUTY_W+BC_W];

   assign stage_wr = wr_en && (wr_addr == ADR_DUTY || wr_addr == ADR_PERIOD);
   assign eff_lock = grp_lock & lock_override;
   assign xfer     = wrap & ~eff_lock;

   // shadow copies and immediate controls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_duty       <= '0;
         sh_frac       <= 1'b0;
         sh_period     <= '0;
         sh_bc         <= '0;
         out_en        <= 1'b0;
         grp_lock      <= 1'b0;
         lock_override <= 1'b0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADR_DUTY: begin
               sh_duty <= wr_data[DUTY_W-1:0];
               sh_frac <= wr_data[DUTY_W];
            end
            ADR_PERIOD: begin
               sh_period <= wr_data[DUTY_W-1:0];
               sh_bc     <= wr_data[DUTY_W+BC_W-1:DUTY_W];
            end
            ADR_ENABLE: out_en <= wr_data[0];
            default: begin
               grp_lock      <= wr_data[0];
               lock_override <= wr_data[1];
            end
         endcase
      end
   end

   // active copies, loaded only at a period boundary with the lock open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_duty   <= '0;
         act_frac   <= 1'b0;
         act_period <= '0;
         act_bc     <= '0;
      end else if (xfer) begin
         act_duty   <= sh_duty;
         act_frac   <= sh_frac;
         act_period <= sh_period;
         act_bc     <= sh_bc;
      end
   end

   // staged-update flag: a new write wins over a same-cycle transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pending <= 1'b0;
      else if (stage_wr) pending <= 1'b1;
      else if (xfer)     pending <= 1'b0;
   end
endmodule

// File: rtl/bl_pwm_counter.sv
module bl_pwm_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_eff,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] last;

   // period_eff is never zero, so last never underflows
   assign last = period_eff - 1'b1;
   assign wrap = (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bl_pwm_dither.sv
module bl_pwm_dither #(
   parameter int unsigned DUTY_W    = 16,
   parameter int unsigned BC_W      = 5,
   parameter bit          DITHER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wrap,
   input  logic              frac_mode,
   input  logic [DUTY_W-1:0] frac,
   input  logic [BC_W-1:0]   frac_w,
   output logic              extra
);
   generate
      if (DITHER_EN) begin : g_acc
         logic [DUTY_W-1:0] acc;
         logic [DUTY_W:0]   sum, fmask;
         logic              carry;

         assign fmask = ~({(DUTY_W+1){1'b1}} << frac_w);
         assign sum   = {1'b0, acc} + {1'b0, frac};
         assign carry = |(sum >> frac_w);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc   <= '0;
               extra <= 1'b0;
            end else if (wrap) begin
               if (frac_mode) begin
                  acc   <= sum[DUTY_W-1:0] & fmask[DUTY_W-1:0];
                  extra <= carry;
               end else begin
                  acc   <= '0;
                  extra <= 1'b0;
               end
            end
         end
      end else begin : g_none
         wire unused_dither = ^{clk, rst_n, wrap, frac_mode, frac, frac_w};
         assign extra = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/bl_pwm_locked.sv
module bl_pwm_locked
   import bl_pwm_pkg::*;
#(
   parameter int unsigned DUTY_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter bit          DITHER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_o,
   output logic              pending_o
);
   localparam int unsigned BC_W = bitcnt_width(DUTY_W);
   localparam logic [BC_W-1:0] FULL_BC = BC_W'(DUTY_W);

   generate
      if (DUTY_W < 2) begin : g_bad_duty
         $error("DUTY_W must be at least 2");
      end
      if (DATA_W <= DUTY_W + BC_W) begin : g_bad_data
         $error("DATA_W must exceed DUTY_W plus the bit-count field");
      end
   endgenerate

   logic [DUTY_W-1:0] act_duty, act_period;
   logic              act_frac;
   logic [BC_W-1:0]   act_bc;
   logic              out_en, eff_lock, xfer, pending, wrap, extra;
   logic [DUTY_W-1:0] cnt;

   bl_pwm_regs #(.DUTY_W(DUTY_W), .BC_W(BC_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wrap(wrap), .act_duty(act_duty),
      .act_frac(act_frac), .act_period(act_period), .act_bc(act_bc),
      .out_en(out_en), .eff_lock(eff_lock), .xfer(xfer), .pending(pending)
   );

   // bit-count decode: 0 or out of range selects full width
   logic [BC_W-1:0]   bc_eff, frac_w;
   logic [DUTY_W-1:0] pmask, pmasked, period_eff;
   logic [DUTY_W-1:0] duty_int, duty_frac;
   logic [DUTY_W:0]   thresh;

   assign bc_eff     = (act_bc == '0 || act_bc > FULL_BC) ? FULL_BC : act_bc;
   assign frac_w     = FULL_BC - bc_eff;
   assign pmask      = ~({DUTY_W{1'b1}} << bc_eff);
   assign pmasked    = act_period & pmask;
   assign period_eff = (pmasked == '0) ? pmask : pmasked;
   assign duty_int   = act_duty >> frac_w;
   assign duty_frac  = act_frac ? (act_duty & ~({DUTY_W{1'b1}} << frac_w)) : '0;

   bl_pwm_counter #(.CNT_W(DUTY_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .period_eff(period_eff),
      .cnt(cnt), .wrap(wrap)
   );

   bl_pwm_dither #(.DUTY_W(DUTY_W), .BC_W(BC_W), .DITHER_EN(DITHER_EN)) u_dith (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .frac_mode(act_frac),
      .frac(duty_frac), .frac_w(frac_w), .extra(extra)
   );

   assign thresh    = {1'b0, duty_int} + {{DUTY_W{1'b0}}, extra};
   assign pwm_o     = out_en & ({1'b0, cnt} < thresh);
   assign pending_o = pending;
endmodule

// File: rtl/bl_pwm_locked_chk.sv
module bl_pwm_locked_chk #(
   parameter int unsigned DUTY_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic              pwm_o,
   input logic              pending_o,
   input logic              out_en,
   input logic              eff_lock,
   input logic              wrap,
   input logic              xfer,
   input logic [DUTY_W-1:0] act_duty,
   input logic [DUTY_W-1:0] cnt,
   input logic [DUTY_W-1:0] period_eff
);
   logic stage_seen;
   assign stage_seen = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);

   assert_pin_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !pwm_o);

   assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < period_eff);

   assert_no_midperiod_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_duty));

   assert_locked_holds_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eff_lock |=> $stable(act_duty));

   assert_locked_keeps_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && eff_lock) |=> pending_o);

   assert_stage_sets_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stage_seen |=> pending_o);

   assert_pending_falls_on_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending_o) |-> ($past(xfer) && cnt == '0));
endmodule

bind bl_pwm_locked bl_pwm_locked_chk #(.DUTY_W(DUTY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .pwm_o(pwm_o), .pending_o(pending_o), .out_en(out_en),
   .eff_lock(eff_lock), .wrap(wrap), .xfer(xfer), .act_duty(act_duty),
   .cnt(cnt), .period_eff(period_eff)
);

// File: tb/bl_pwm_locked_test.sv
`timescale 1ns/1ps
module bl_pwm_locked_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pwm_o, pending_o;
   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bl_pwm_locked uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o), .pending_o(pending_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_clear(input string req, input int max);
      int k = 0;
      while (pending_o && k < max) begin
         @(negedge clk);
         k++;
      end
      check(req, pending_o, 0);
   endtask

   // aligns on a rising pin edge, then counts high cycles and length over nper periods
   task automatic measure(input int nper, output int hi, output int len);
      int t = 0;
      int seen = 0;
      logic prev;
      hi = 0; len = 0;
      while (pwm_o && t < 70000) begin @(negedge clk); t++; end
      while (!pwm_o && t < 140000) begin @(negedge clk); t++; end
      while (seen < nper && len < 70000) begin
         hi += int'(pwm_o); len++;
         prev = pwm_o;
         @(negedge clk);
         if (!prev && pwm_o) seen++;
      end
   endtask

   task automatic hold_level(input string req, input int cycles, input logic lvl);
      int bad = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (pwm_o != lvl) bad++;
      end
      check(req, bad, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 pin low after reset", pwm_o, 0);
      check("R1 pending low after reset", pending_o, 0);
   endtask

   task automatic t_program;
      int hi, len;
      wr(2'd1, 32'h0008_0164);
      check("R11 pending after period write", pending_o, 1);
      wr(2'd0, 32'h0000_2800);
      wr(2'd2, 32'h1);
      wait_clear("R11 pending clears at boundary", 70000);
      measure(1, hi, len);
      check("R3 masked period length", len, 100);
      check("R5 integer duty high count", hi, 40);
   endtask

   task automatic t_disable;
      wr(2'd2, 32'h0);
      hold_level("R2 disabled pin low", 250, 1'b0);
      wr(2'd2, 32'h1);
   endtask

   task automatic t_boundary;
      int hi, len, t;
      logic prev_p;
      while (pwm_o) @(negedge clk);
      while (!pwm_o) @(negedge clk);   // counter now at 0
      wr(2'd0, 32'h0000_4600);           // counter at 2 after this
      check("R11 pending set mid-period", pending_o, 1);
      repeat (48) @(negedge clk);        // counter at 50
      check("R8 old duty kept for rest of period", pwm_o, 0);
      check("R8 still pending before boundary", pending_o, 1);
      prev_p = pending_o; t = 0;
      while (!pwm_o && t < 200) begin prev_p = pending_o; @(negedge clk); t++; end
      check("R11 pending falls in first cycle of period", pending_o, 0);
      check("R11 pending high until that cycle", prev_p, 1);
      measure(1, hi, len);
      check("R8 new duty from next period", hi, 70);
   endtask

   task automatic t_lock;
      int hi, len;
      wr(2'd3, 32'h3);
      wr(2'd0, 32'h0000_1400);
      measure(3, hi, len);
      check("R9 locked duty unchanged", hi, 210);
      check("R9 pending held while locked", pending_o, 1);
      wr(2'd3, 32'h0);
      wait_clear("R9 release applies at boundary", 150);
      measure(1, hi, len);
      check("R9 released duty", hi, 20);
   endtask

   task automatic t_lock_no_override;
      int hi, len;
      wr(2'd3, 32'h1);
      wr(2'd0, 32'h0000_3200);
      wait_clear("R10 lock without override ignored", 150);
      measure(1, hi, len);
      check("R10 duty applied despite lock bit", hi, 50);
      wr(2'd3, 32'h0);
   endtask

   task automatic t_nonfrac;
      int hi, len;
      wr(2'd0, 32'h0000_2880);
      wait_clear("R6 pending clears", 150);
      measure(4, hi, len);
      check("R6 low bits ignored without dither", hi, 160);
   endtask

   task automatic t_frac;
      int hi, len;
      wr(2'd0, 32'h0001_2880);
      wait_clear("R7 pending clears", 150);
      measure(1, hi, len);
      measure(4, hi, len);
      check("R7 dither high count over four periods", hi, 162);
      check("R7 dither keeps period length", len, 400);
   endtask

   task automatic t_extremes;
      wr(2'd0, 32'h0000_0000);
      wait_clear("R5 pending clears", 150);
      repeat (110) @(negedge clk);
      hold_level("R5 zero duty constant low", 250, 1'b0);
      wr(2'd0, 32'h0000_6400);
      wait_clear("R5 pending clears", 150);
      hold_level("R5 duty equal to period constant high", 250, 1'b1);
      wr(2'd0, 32'h0000_FF00);
      wait_clear("R5 pending clears", 150);
      hold_level("R5 duty above period constant high", 250, 1'b1);
   endtask

   task automatic t_period_zero;
      int hi, len;
      wr(2'd1, 32'h0004_0000);
      wr(2'd0, 32'h0000_5000);
      wait_clear("R4 pending clears", 300);
      measure(1, hi, len);
      measure(1, hi, len);
      check("R4 zero period gives all ones of bit-count", len, 15);
      check("R4 duty under short period", hi, 5);
   endtask

   task automatic t_bc_zero;
      int hi, len;
      wr(2'd1, 32'h0000_012C);
      wr(2'd0, 32'h0000_0078);
      wait_clear("R3 pending clears", 400);
      measure(1, hi, len);
      check("R3 bit-count zero means full width period", len, 300);
      check("R3 full width integer duty", hi, 120);
   endtask

   initial begin
      #(180000 * 10);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_disable();
      t_boundary();
      t_lock();
      t_lock_no_override();
      t_nonfrac();
      t_frac();
      t_extremes();
      t_period_zero();
      t_bc_zero();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule